// File: doc/BRIEF.md
# Filtered Quadrature Position Decoder with Index Qualification

This block turns the two phase signals of an incremental encoder into a signed position count. It also takes an optional index input. Each of the three inputs first passes through a glitch filter. The filter forwards a new level only after the raw input has held that level for a programmable number of consecutive clock samples. The filtered phase pair drives a Gray-code step classifier. Each legal step moves a 16-bit wrapping counter up or down by one and records the direction. A step in which both phases change at once is counted as an error.

The index input is qualified by the phase state. An index is accepted only when the index input is high, index use is enabled, and the filtered phase pair equals a programmable 2-bit state. On acceptance the counter returns to zero and a single-cycle index pulse is emitted. All settings come from one 8-bit control word:

| Bits | Meaning |
|------|---------|
| 2:0 | Filter length |
| 3 | Decode enable |
| 4 | Index enable |
| 6:5 | Index state |
| 7 | Unused |

Top module: `qdec_top`

## Requirements
- R1: A raw input change reaches the decoder only after the input has been sampled at the new level on N consecutive clock edges, with N = ctrl_word[2:0] + 1. A pulse held for fewer than N samples is discarded.
- R2: Filter length codes 4 through 7 (ctrl_word[2:0] = 100 to 111) all use N = 5.
- R3: With ctrl_word[3] = 1, each filtered step along {ph_a, ph_b} = 00→01→11→10→00 adds one to `count` and sets `dir_up` to 1.
- R4: With ctrl_word[3] = 1, each filtered step along the reverse order 00→10→11→01→00 subtracts one from `count` and clears `dir_up` to 0.
- R5: A filtered change of both phases in the same cycle sets `step_err`, and `step_err` stays set until reset. Such a change leaves `count` unchanged.
- R6: While ctrl_word[3] = 0, `count` does not change. The decoder keeps tracking the phase state, so re-enabling does not create a step.
- R7: When ctrl_word[3] = 1, ctrl_word[4] = 1, the filtered index is high and the filtered {ph_a, ph_b} equals ctrl_word[6:5], `count` becomes zero and `idx_pulse` is high for exactly one cycle. This happens once each time the condition becomes true.
- R8: No index pulse or counter reload occurs when ctrl_word[4] = 0 or when the phase state differs from ctrl_word[6:5], even with the index input high.
- R9: A synchronous active-high `rst` clears the filters, `count`, `dir_up`, `step_err` and `idx_pulse` to zero.
- R10: `count` wraps modulo 2^16: a down step from 0 gives 16'hFFFF, and an up step from 16'hFFFF gives 0.
- R11: ctrl_word[7] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 8 | Configuration word (filter length, enables, index state) |
| ph_a | input | 1 | Raw encoder phase A (first bit of the phase pair) |
| ph_b | input | 1 | Raw encoder phase B (second bit of the phase pair) |
| idx_in | input | 1 | Raw encoder index |
| count | output | 16 | Position counter |
| dir_up | output | 1 | Direction of the most recent legal step (1 = up) |
| idx_pulse | output | 1 | One-cycle pulse on an accepted index |
| step_err | output | 1 | Sticky flag for a two-phase change |

## Verification
The phases are driven through full forward and reverse Gray cycles, including a reverse step from zero. This separates up from down counting and exposes wrap-around. Short and just-long-enough pulses are applied at filter lengths 4 and 7. These pulses show whether the sample threshold is N or off by one, and whether the top codes saturate at five. A jump across both phases tells an illegal step apart from a legal one. Holding the index high while the phases move through matching and mismatching states, with index use on and then off, shows that only the selected state reloads the counter and that each entry into it gives exactly one pulse.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef struct packed {
        logic       spare;
        logic [1:0] idx_state;
        logic       idx_use;
        logic       dec_on;
        logic [2:0] filt_code;
    } qdec_cfg_t;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_BAD  = 2'd2,
        STEP_DOWN = 2'd3
    } step_e;

    localparam int unsigned FILT_MAX = 5;

    // Position of a phase pair along the forward Gray order 00,01,11,10
    function automatic logic [1:0] gray_pos(input logic [1:0] s);
        return {s[1], s[1] ^ s[0]};
    endfunction

    // Sample count required by a filter code, saturating at FILT_MAX
    function automatic logic [2:0] filt_need(input logic [2:0] code);
        if (code >= 3'(FILT_MAX - 1))
            return 3'(FILT_MAX);
        return code + 3'd1;
    endfunction

endpackage

// File: rtl/qdec_glitch_filter.sv
module qdec_glitch_filter #(
    parameter int RUN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw,
    input  logic [RUN_W-1:0] need,
    output logic             filt
);
    logic [RUN_W-1:0] run;
    logic [RUN_W:0]   run_next;

    assign run_next = {1'b0, run} + {{RUN_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            filt <= 1'b0;
            run  <= '0;
        end else if (raw == filt) begin
            run  <= '0;
        end else if (run_next >= {1'b0, need}) begin
            filt <= raw;
            run  <= '0;
        end else begin
            run  <= run_next[RUN_W-1:0];
        end
    end
endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] phase,
    output step_e      step
);
    logic [1:0] prev;
    logic [1:0] delta;

    always_ff @(posedge clk) begin
        if (rst) prev <= 2'b00;
        else     prev <= phase;
    end

    assign delta = gray_pos(phase) - gray_pos(prev);

    always_comb begin
        unique case (delta)
            2'd0:    step = STEP_NONE;
            2'd1:    step = STEP_UP;
            2'd3:    step = STEP_DOWN;
            default: step = STEP_BAD;
        endcase
    end
endmodule

// File: rtl/qdec_index_qual.sv
module qdec_index_qual (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       idx_filt,
    input  logic [1:0] phase,
    input  logic [1:0] want,
    output logic       hit,
    output logic       pulse
);
    logic match;
    logic match_q;

    assign match = enable & idx_filt & (phase == want);
    assign hit   = match & ~match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= 1'b0;
            pulse   <= 1'b0;
        end else begin
            match_q <= match;
            pulse   <= hit;
        end
    end
endmodule

// File: rtl/qdec_position.sv
module qdec_position
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  step_e            step,
    input  logic             reload,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             err
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            dir_up <= 1'b0;
            err    <= 1'b0;
        end else if (enable) begin
            unique case (step)
                STEP_UP:   dir_up <= 1'b1;
                STEP_DOWN: dir_up <= 1'b0;
                STEP_BAD:  err    <= 1'b1;
                default:   ;
            endcase
            if (reload)
                count <= '0;
            else if (step == STEP_UP)
                count <= count + ONE;
            else if (step == STEP_DOWN)
                count <= count - ONE;
        end
    end
endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       ctrl_word,
    input  logic             ph_a,
    input  logic             ph_b,
    input  logic             idx_in,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             idx_pulse,
    output logic             step_err
);
    localparam int NUM_IN = 3;
    localparam int RUN_W  = 3;

    qdec_cfg_t         cfg;
    logic [RUN_W-1:0]  need;
    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] filt_in;
    logic [1:0]        phase;
    step_e             step;
    logic              idx_hit;
    logic              unused_spare;

    assign cfg          = qdec_cfg_t'(ctrl_word);
    assign unused_spare = cfg.spare;
    assign need         = filt_need(cfg.filt_code);
    assign raw_in       = {idx_in, ph_b, ph_a};
    assign phase        = {filt_in[0], filt_in[1]};

    for (genvar i = 0; i < NUM_IN; i++) begin : g_filt
        qdec_glitch_filter #(.RUN_W(RUN_W)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_in[i]),
            .need (need),
            .filt (filt_in[i])
        );
    end

    qdec_step_decode u_step (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .step  (step)
    );

    qdec_index_qual u_idx (
        .clk      (clk),
        .rst      (rst),
        .enable   (cfg.dec_on & cfg.idx_use),
        .idx_filt (filt_in[2]),
        .phase    (phase),
        .want     (cfg.idx_state),
        .hit      (idx_hit),
        .pulse    (idx_pulse)
    );

    qdec_position #(.CNT_W(CNT_W)) u_pos (
        .clk    (clk),
        .rst    (rst),
        .enable (cfg.dec_on),
        .step   (step),
        .reload (idx_hit),
        .count  (count),
        .dir_up (dir_up),
        .err    (step_err)
    );
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             dec_on,
    input logic [CNT_W-1:0] count,
    input logic             dir_up,
    input logic             idx_pulse,
    input logic             step_err
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_IDX_SINGLE: assert property (@(posedge clk) disable iff (rst)
        idx_pulse |=> !idx_pulse);                                        // R7
    AST_IDX_ZEROES: assert property (@(posedge clk) disable iff (rst)
        idx_pulse |-> count == '0);                                       // R7
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        !dec_on |=> $stable(count) && !idx_pulse);                        // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        step_err |=> step_err);                                           // R5
    AST_UNIT_MOVE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> idx_pulse || count == $past(count)
                 || count == $past(count) + ONE
                 || count == $past(count) - ONE);                         // R3
    AST_DIR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> idx_pulse || count != $past(count) + ONE || dir_up);     // R3
endmodule

bind qdec_top qdec_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dec_on    (ctrl_word[3]),
    .count     (count),
    .dir_up    (dir_up),
    .idx_pulse (idx_pulse),
    .step_err  (step_err)
);

// File: tb/qdec_top_test.sv
`timescale 1ns/1ps
module qdec_top_test;
    localparam int HOLD = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ctrl_word = 8'h00;
    logic        ph_a = 1'b0, ph_b = 1'b0, idx_in = 1'b0;
    logic [15:0] count;
    logic        dir_up, idx_pulse, step_err;
    int          nchk = 0, nfail = 0, npulse = 0;

    always #10 clk = ~clk;

    qdec_top uut (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word),
        .ph_a(ph_a), .ph_b(ph_b), .idx_in(idx_in),
        .count(count), .dir_up(dir_up), .idx_pulse(idx_pulse), .step_err(step_err)
    );

    always @(negedge clk) if (idx_pulse) npulse++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; ph_a = 0; ph_b = 0; idx_in = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic move(input logic a, input logic b);
        @(negedge clk); ph_a = a; ph_b = b;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R9 count", count, 0);
        check("R9 dir", dir_up, 0);
        check("R9 err", step_err, 0);
        check("R9 pulse", idx_pulse, 0);
    endtask

    task automatic t_up();
        do_reset(); ctrl_word = 8'h08;
        move(0,1); move(1,1); move(1,0); move(0,0);
        check("R3 up count", count, 4);
        check("R3 dir", dir_up, 1);
    endtask

    task automatic t_down();
        move(1,0);
        check("R4 down count", count, 3);
        check("R4 dir", dir_up, 0);
        move(1,1); move(0,1); move(0,0);
        check("R4 down to zero", count, 0);
        move(1,0);
        check("R10 wrap down", count, 16'hFFFF);
        move(0,0);
        check("R10 wrap up", count, 0);
    endtask

    task automatic t_filter();
        do_reset(); ctrl_word = 8'h0B;               // N = 4
        @(negedge clk); ph_b = 1;
        repeat (3) @(negedge clk); ph_b = 0;
        repeat (HOLD) @(negedge clk);
        check("R1 short pulse rejected", count, 0);
        @(negedge clk); ph_b = 1;
        repeat (4) @(negedge clk);
        repeat (HOLD) @(negedge clk);
        check("R1 full pulse accepted", count, 1);
    endtask

    task automatic t_sat();
        ctrl_word = 8'h0F;                           // code 7 -> N = 5
        @(negedge clk); ph_a = 1;
        repeat (4) @(negedge clk); ph_a = 0;
        repeat (HOLD) @(negedge clk);
        check("R2 four samples rejected", count, 1);
        @(negedge clk); ph_a = 1;
        repeat (5) @(negedge clk);
        repeat (HOLD) @(negedge clk);
        check("R2 five samples accepted", count, 2);
    endtask

    task automatic t_spare();
        do_reset(); ctrl_word = 8'h88;
        move(0,1); move(1,1);
        check("R11 spare bit ignored", count, 2);
        check("R11 dir", dir_up, 1);
    endtask

    task automatic t_disable();
        do_reset(); ctrl_word = 8'h00;
        move(0,1); move(1,1);
        check("R6 held while off", count, 0);
        ctrl_word = 8'h08;
        repeat (HOLD) @(negedge clk);
        check("R6 no step on enable", count, 0);
        move(1,0);
        check("R6 counts after enable", count, 1);
    endtask

    task automatic t_illegal();
        do_reset(); ctrl_word = 8'h08;
        move(1,1);
        check("R5 err set", step_err, 1);
        check("R5 count kept", count, 0);
        move(1,0);
        check("R5 err sticky", step_err, 1);
        check("R5 later step counts", count, 1);
        do_reset();
        t_reset();
    endtask

    task automatic t_index();
        do_reset(); ctrl_word = 8'h78;               // state 11, index on
        npulse = 0;
        move(0,1);
        @(negedge clk); idx_in = 1;
        repeat (HOLD) @(negedge clk);
        check("R8 mismatch state no pulse", npulse, 0);
        check("R8 mismatch count", count, 1);
        move(1,1);
        check("R7 reload", count, 0);
        check("R7 one pulse", npulse, 1);
        move(1,0);
        check("R7 counts on", count, 1);
        move(1,1);
        check("R7 second entry", npulse, 2);
        check("R7 second reload", count, 0);
        ctrl_word = 8'h68;                           // index use off
        move(1,0); move(0,0); move(0,1); move(1,1);
        check("R8 index off no reload", count, 4);
        check("R8 index off no pulse", npulse, 2);
        idx_in = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_up();
        t_down();
        t_filter();
        t_sat();
        t_spare();
        t_disable();
        t_illegal();
        t_index();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule